// File: doc/BRIEF.md
# Ring Controller Host Register Interface

This block is the host-facing register front end of a descriptor-ring Ethernet controller. The host sees two halfword locations. One holds a register-select pointer. The other is a data window onto whichever internal control/status register the pointer currently selects. Register 0 is the master control/status word. Registers 1 and 2 together form the 32-bit address of the initialization block. Register 3 holds bus-mode options. Any registers added by raising `NREG` are plain storage.

The master word follows a set of fixed write rules:
- A stop command wipes the word.
- Event flags clear when written with one.
- The error and interrupt summaries are always rebuilt from the flags.
- The interrupt enable is copied from the written value.
- Start and init are commands, and init wins when both are given.

Event flags come from the ring engine through a set-pulse input and latch only while the controller is not stopped. The interrupt output is active while both the interrupt summary and the enable are set.

Top module: `csr_ring_host_if`

## Requirements
- R1: After reset the master word reads 0x0004 (only the stop flag, bit 2, set), the pointer reads 0, registers 1 to 3 read 0, `irq` is 0, `init_ptr` is 0 and `bus_mode` is 0.
- R2: A write with `bus_sel`=1 loads the pointer only when the value is below `NREG` (4 by default); any other value leaves the pointer unchanged. A read with `bus_sel`=1 returns the pointer, zero-extended.
- R3: A read with `bus_sel`=0 returns the register the pointer selects, and a write with `bus_sel`=0 updates only that register.
- R4: Writing the master word with bit 2 set makes it exactly 0x0004, whatever the other written bits are.
- R5: In a master-word write without bit 2, a one in any of bits 14 to 8 clears that flag, and a zero leaves it unchanged.
- R6: After every update, bit 15 equals the OR of bits 14 to 11, and bit 7 equals the OR of bits 14 to 8.
- R7: In a master-word write without bit 2, bit 6 (interrupt enable) takes the written value.
- R8: In a master-word write without bit 2, a one in bit 0 sets bits 0 and 8 and clears bit 2. Bit 1 is then not acted on.
- R9: In a master-word write without bits 2 and 0, a one in bit 1 sets bits 1, 5 and 4 and clears bit 2.
- R10: `init_ptr` is register 2 in its upper half and register 1 in its lower half. Register 3 keeps all 16 written bits, and `bus_mode` shows its bits 2 to 0.
- R11: `irq` is 1 exactly when bits 7 and 6 of the master word are both 1.
- R12: `evt_set[k]` sets master-word bit 8+k on the next edge, but only if bit 2 was 0 before that edge. An event that coincides with a host clear of the same flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe for this cycle |
| bus_sel | input | 1 | 0 selects the data window, 1 selects the pointer |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for the location chosen by `bus_sel` |
| evt_set | input | 7 | Set pulses for master-word flags 14 to 8 |
| irq | output | 1 | Interrupt request |
| init_ptr | output | 32 | Initialization-block address |
| bus_mode | output | 3 | Bus-mode option bits from register 3 |

## Verification
The bench sweeps every combination of the seven clearable flags against a fully set word. A design that recomputed the summaries before clearing, or that folded the init-done flag into the error summary, would show a stale bit 15 or bit 7 and a wrong `irq`. All eight patterns of the three command bits are applied from both the stopped and the running state. This catches a start that overrides init, a stop that keeps other bits, or a command that leaves bit 2 set. Pointer values 0 to 7 are written in turn, so an unchecked pointer load shows up as a wrong pointer readback. Two event cases close the sweep: events arriving while stopped, and an event that collides with a clear of the same flag. These expose merge-order and gating mistakes.

// File: rtl/csr_ring_pkg.sv
package csr_ring_pkg;
   localparam int WORD_W = 16;
   typedef logic [WORD_W-1:0] word_t;

   // master word bit positions
   localparam int B_INIT = 0;
   localparam int B_STRT = 1;
   localparam int B_STOP = 2;
   localparam int B_TXON = 4;
   localparam int B_RXON = 5;
   localparam int B_INEA = 6;
   localparam int B_INTR = 7;
   localparam int B_IDON = 8;
   localparam int B_ERR  = 15;
   localparam int EVT_LO = 8;
   localparam int EVT_HI = 14;
   localparam int ERR_LO = 11;
   localparam int EVT_W  = EVT_HI - EVT_LO + 1;

   localparam word_t CSR0_RESET = word_t'(1) << B_STOP;

   // rebuild the two summary bits from the flag field
   function automatic word_t summarize(input word_t w);
      word_t r;
      r = w;
      r[B_ERR]  = |w[EVT_HI:ERR_LO];
      r[B_INTR] = |w[EVT_HI:EVT_LO];
      return r;
   endfunction
endpackage

// File: rtl/csr_ptr_dec.sv
module csr_ptr_dec
   import csr_ring_pkg::*;
#(
   parameter int NREG  = 4,
   parameter int PTR_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_sel,
   input  word_t            bus_wdata,
   output logic [PTR_W-1:0] ptr_q,
   output logic [NREG-1:0]  reg_we
);
   logic ptr_ok;

   assign ptr_ok = (32'(bus_wdata) < NREG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (bus_wr && bus_sel && ptr_ok) begin
         ptr_q <= bus_wdata[PTR_W-1:0];
      end
   end

   for (genvar i = 0; i < NREG; i++) begin : g_we
      assign reg_we[i] = bus_wr && !bus_sel && (ptr_q == PTR_W'(i));
   end
endmodule

// File: rtl/csr0_ctrl.sv
module csr0_ctrl
   import csr_ring_pkg::*;
(
   input  word_t            cur,
   input  logic             wr,
   input  word_t            wdata,
   input  logic [EVT_W-1:0] evt,
   output word_t            nxt
);
   word_t r;

   always_comb begin
      r = cur;
      if (wr && wdata[B_STOP]) begin
         nxt = CSR0_RESET;
      end else begin
         if (wr) begin
            r[EVT_HI:EVT_LO] = r[EVT_HI:EVT_LO] & ~wdata[EVT_HI:EVT_LO];
            r[B_INEA] = wdata[B_INEA];
            if (wdata[B_INIT]) begin
               r[B_INIT] = 1'b1;
               r[B_IDON] = 1'b1;
               r[B_STOP] = 1'b0;
            end else if (wdata[B_STRT]) begin
               r[B_STRT] = 1'b1;
               r[B_RXON] = 1'b1;
               r[B_TXON] = 1'b1;
               r[B_STOP] = 1'b0;
            end
         end
         if (!cur[B_STOP]) begin
            r[EVT_HI:EVT_LO] = r[EVT_HI:EVT_LO] | evt;
         end
         nxt = summarize(r);
      end
   end
endmodule

// File: rtl/csr_aux_regs.sv
module csr_aux_regs
   import csr_ring_pkg::*;
#(
   parameter int NREG = 4,
   localparam int NAUX = NREG - 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NREG-1:0]        we,
   input  word_t                  wdata,
   output logic [NAUX*WORD_W-1:0] regs_flat
);
   for (genvar i = 1; i < NREG; i++) begin : g_reg
      word_t q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we[i]) begin
            q <= wdata;
         end
      end
      assign regs_flat[(i-1)*WORD_W +: WORD_W] = q;
   end
endmodule

// File: rtl/csr_ring_host_if.sv
module csr_ring_host_if
   import csr_ring_pkg::*;
#(
   parameter int NREG      = 4,
   parameter bit REG_RDATA = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_sel,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   input  logic [6:0]  evt_set,
   output logic        irq,
   output logic [31:0] init_ptr,
   output logic [2:0]  bus_mode
);
   localparam int PTR_W = (NREG > 1) ? $clog2(NREG) : 1;
   localparam int NAUX  = NREG - 1;

   if (NREG < 4) begin : g_bad_nreg
      $error("csr_ring_host_if: NREG must be at least 4");
   end
   if (WORD_W != 16) begin : g_bad_width
      $error("csr_ring_host_if: word width must be 16");
   end

   logic [PTR_W-1:0]        ptr_q;
   logic [NREG-1:0]         reg_we;
   word_t                   csr0_q;
   word_t                   csr0_d;
   logic [NAUX*WORD_W-1:0]  aux_flat;
   word_t                   rd_word;

   csr_ptr_dec #(.NREG(NREG), .PTR_W(PTR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_sel  (bus_sel),
      .bus_wdata(bus_wdata),
      .ptr_q    (ptr_q),
      .reg_we   (reg_we)
   );

   csr0_ctrl u_csr0 (
      .cur  (csr0_q),
      .wr   (reg_we[0]),
      .wdata(bus_wdata),
      .evt  (evt_set),
      .nxt  (csr0_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) csr0_q <= CSR0_RESET;
      else        csr0_q <= csr0_d;
   end

   csr_aux_regs #(.NREG(NREG)) u_aux (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .wdata    (bus_wdata),
      .regs_flat(aux_flat)
   );

   always_comb begin
      rd_word = '0;
      if (bus_sel) begin
         rd_word = word_t'(ptr_q);
      end else if (ptr_q == '0) begin
         rd_word = csr0_q;
      end else begin
         for (int i = 1; i < NREG; i++) begin
            if (ptr_q == PTR_W'(i)) rd_word = aux_flat[(i-1)*WORD_W +: WORD_W];
         end
      end
   end

   if (REG_RDATA) begin : g_rd_reg
      word_t rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_word;
      end
      assign bus_rdata = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_word;
   end

   assign irq      = csr0_q[B_INTR] & csr0_q[B_INEA];
   assign init_ptr = {aux_flat[WORD_W +: WORD_W], aux_flat[0 +: WORD_W]};
   assign bus_mode = aux_flat[2*WORD_W +: 3];
endmodule

// File: rtl/csr_ring_host_if_chk.sv
module csr_ring_host_if_chk #(
   parameter int NREG  = 4,
   localparam int PTR_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_sel,
   input logic [15:0]      bus_wdata,
   input logic             irq,
   input logic [15:0]      csr0,
   input logic [PTR_W-1:0] ptr
);
   logic csr0_wr;
   assign csr0_wr = bus_wr && !bus_sel && (ptr == '0);

   p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr) < NREG);

   p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel && (32'(bus_wdata) >= NREG)) |=> $stable(ptr));

   p_stop_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (csr0_wr && bus_wdata[2]) |=> (csr0 == 16'h0004));

   p_err_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      csr0[15] == (|csr0[14:11]));

   p_intr_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      csr0[7] == (|csr0[14:8]));

   p_inea_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (csr0_wr && !bus_wdata[2]) |=> (csr0[6] == $past(bus_wdata[6])));

   p_init_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (csr0_wr && !bus_wdata[2] && bus_wdata[0]) |=> (csr0[0] && csr0[8] && !csr0[2]));

   p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|csr0[14:8]));

   p_stopped_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (csr0[2] && !csr0_wr) |=> $stable(csr0));
endmodule

bind csr_ring_host_if csr_ring_host_if_chk #(.NREG(NREG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_sel  (bus_sel),
   .bus_wdata(bus_wdata),
   .irq      (irq),
   .csr0     (csr0_q),
   .ptr      (ptr_q)
);

// File: tb/csr_ring_host_if_test.sv
module csr_ring_host_if_test;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_sel = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [6:0]  evt_set = '0;
   logic        irq;
   logic [31:0] init_ptr;
   logic [2:0]  bus_mode;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [15:0] exp_c0;
   logic [15:0] exp_ptr;

   always #(CLK_PERIOD/2) clk = ~clk;

   csr_ring_host_if #(.NREG(NREG)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
      .irq(irq), .init_ptr(init_ptr), .bus_mode(bus_mode)
   );

   function automatic logic [15:0] summ(input logic [15:0] w);
      logic [15:0] r;
      r = w;
      r[15] = |w[14:11];
      r[7]  = |w[14:8];
      return r;
   endfunction

   // expected master word after a host write plus same-cycle events
   function automatic logic [15:0] model(input logic [15:0] cur, input logic [15:0] w,
                                         input logic wr, input logic [6:0] ev);
      logic [15:0] r;
      if (wr && w[2]) return 16'h0004;
      r = cur;
      if (wr) begin
         r[14:8] = r[14:8] & ~w[14:8];
         r[6] = w[6];
         if (w[0]) begin r[0] = 1; r[8] = 1; r[2] = 0; end
         else if (w[1]) begin r[1] = 1; r[5] = 1; r[4] = 1; r[2] = 0; end
      end
      if (!cur[2]) r[14:8] = r[14:8] | ev;
      return summ(r);
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [15:0] d, input logic [6:0] ev = '0);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = sel; bus_wdata = d; evt_set = ev;
      @(negedge clk);
      bus_wr = 1'b0; evt_set = '0;
   endtask

   task automatic rd(input logic sel, output logic [15:0] v);
      bus_sel = sel;
      #1;
      v = bus_rdata;
   endtask

   task automatic set_ptr(input logic [15:0] p);
      wr(1'b1, p);
      exp_ptr = p;
   endtask

   task automatic c0_write(input logic [15:0] w, input logic [6:0] ev = '0);
      wr(1'b0, w, ev);
      exp_c0 = model(exp_c0, w, 1'b1, ev);
   endtask

   task automatic c0_event(input logic [6:0] ev);
      @(negedge clk);
      evt_set = ev;
      @(negedge clk);
      evt_set = '0;
      exp_c0 = model(exp_c0, 16'h0, 1'b0, ev);
   endtask

   task automatic chk_c0(input string tag);
      logic [15:0] v;
      rd(1'b0, v);
      chk(tag, {16'h0, v}, {16'h0, exp_c0});
      chk({tag, " R11 irq"}, {31'h0, irq}, {31'h0, exp_c0[7] & exp_c0[6]});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL R1 watchdog got=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      exp_c0 = 16'h0004;
      exp_ptr = 16'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_c0("R1 master word");
      rd(1'b1, v); chk("R1 pointer", {16'h0, v}, 32'h0);
      chk("R1 init_ptr", init_ptr, 32'h0);
      chk("R1 bus_mode", {29'h0, bus_mode}, 32'h0);
      for (int i = 1; i < NREG; i++) begin
         set_ptr(16'(i)); rd(1'b0, v); chk("R1 aux reg", {16'h0, v}, 32'h0);
      end

      // R2 pointer sweep, in-range and out-of-range values
      for (int p = 0; p < 8; p++) begin
         wr(1'b1, 16'(p));
         if (p < NREG) exp_ptr = 16'(p);
         rd(1'b1, v); chk("R2 pointer load", {16'h0, v}, {16'h0, exp_ptr});
      end
      wr(1'b1, 16'hFFFF);
      rd(1'b1, v); chk("R2 large value ignored", {16'h0, v}, {16'h0, exp_ptr});

      // R3 / R10 auxiliary registers
      set_ptr(16'd1); wr(1'b0, 16'hBEEF);
      set_ptr(16'd2); wr(1'b0, 16'h1234);
      set_ptr(16'd3); wr(1'b0, 16'hA5A6);
      chk("R10 init_ptr", init_ptr, 32'h1234BEEF);
      chk("R10 bus_mode", {29'h0, bus_mode}, 32'h6);
      rd(1'b0, v); chk("R10 reg3 full word", {16'h0, v}, 32'hA5A6);
      set_ptr(16'd1); rd(1'b0, v); chk("R3 reg1 readback", {16'h0, v}, 32'hBEEF);
      set_ptr(16'd2); wr(1'b0, 16'h00C0);
      chk("R10 init_ptr high", init_ptr, 32'h00C0BEEF);
      set_ptr(16'd0);
      chk_c0("R3 master untouched by aux writes");

      // command sweep from stopped and running states (R4 R7 R8 R9)
      for (int st = 0; st < 2; st++) begin
         for (int cmd = 0; cmd < 8; cmd++) begin
            c0_write(16'h0004);
            if (st == 1) c0_write(16'h0002);
            c0_write(16'(cmd) | ((cmd & 1) ? 16'h0040 : 16'h0000) | 16'h7F00);
            case (cmd & 7)
               4, 5, 6, 7: chk_c0("R4 stop command");
               1, 3:       chk_c0("R8 init command");
               2:          chk_c0("R9 start command");
               default:    chk_c0("R7 no command");
            endcase
         end
      end

      // R5 R6 R11 clear sweep over every flag pattern
      for (int pat = 0; pat < 128; pat++) begin
         c0_write(16'h0002);
         c0_event(7'h7F);
         c0_write({1'b0, 7'(pat), 8'h00} | ((pat & 1) ? 16'h0000 : 16'h0040));
         chk_c0("R5 R6 clear pattern");
      end

      // R12 events gated by stop, merged after clear
      c0_write(16'h0004);
      c0_event(7'h7F);
      chk_c0("R12 events while stopped");
      c0_write(16'h0042);
      c0_event(7'h04);
      chk_c0("R12 event latched");
      c0_write(16'h0440, 7'h04);
      chk_c0("R12 event beats clear");
      c0_write(16'h0040, 7'h01);
      chk_c0("R12 event with plain write");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule